// File: doc/BRIEF.md
# XOR-Coded Multi-Ported Memory

This block is a word-addressed memory with a configurable number of write ports and read ports. It is built only from simple banks that each have one write port and one read port. Every port reaches every address, and a word written through any write port can be read back through any read port.

Each write port owns a group of banks. The group has one bank for each read port and one bank for each other write port. A write port always stores the same encoded value into every bank of its group. The encoded value is the new data XOR-ed with the words that the other write ports' groups currently hold at that address. A read port recovers the word by XOR-ing together its own bank from every group. This works because the XOR of all groups' entries at an address always equals the last word written there.

A write needs two cycles. In the first cycle the port fetches the other groups' entries. In the second cycle it commits the encoded value. A read returns its data one cycle after the address is sampled, and reads can be issued every cycle. There is no forwarding of a write that has not yet committed. Writes from different ports to one address in overlapping cycles give an undefined result, and the user must avoid them.

Top module: `xor_mp_mem`

## Requirements
- R1: After reset every address reads as zero on every read port.
- R2: A word written through any write port is returned by every read port, including after the same address is rewritten through a different write port.
- R3: A write whose request is sampled at clock edge n is seen by reads sampled at edge n+2 or later. Reads sampled at edges n and n+1 return the previous word.
- R4: Read data for an address sampled at edge n is presented on the read port's data slice right after edge n (one cycle of latency).
- R5: Each read port accepts a new address on every cycle with no stall, also while writes run on every write port.
- R6: Different write ports writing different addresses in the same cycle all take effect.
- R7: A write port whose enable bit is low changes no stored word, whatever its address and data inputs carry.
- R8: Read ports work independently. Ports given the same address in the same cycle return identical data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears every bank and the write stage |
| wr_en | input | NUM_WR | Bit k requests a write through write port k |
| wr_addr | input | NUM_WR*ADDR_W | Write port k's address in bits [k*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR*DATA_W | Write port k's data in bits [k*DATA_W +: DATA_W] |
| rd_addr | input | NUM_RD*ADDR_W | Read port k's address in bits [k*ADDR_W +: ADDR_W] |
| rd_data | output | NUM_RD*DATA_W | Read port k's data in bits [k*DATA_W +: DATA_W], one cycle after its address |

## Verification
In the same cycle, a read can sample an address whose two-stage write is still in flight. That write's commit can also coincide with another port's first-stage fetch from the same group. The bench causes the first case directly, by reading the target address on the request cycle, the commit cycle and the cycle after. It causes both cases at random with free-running reads on every port, beside writes restricted only so that no two ports touch one address within a cycle of each other. A behavioural model applies each write one edge after its request, reads before committing, and is compared with every read port on every cycle.

// File: rtl/xor_mp_pkg.sv
package xor_mp_pkg;

    // Slot inside write port `owner`'s bank group that serves write port `peer`.
    // Slots 0..num_rd-1 serve the read ports; the remaining slots serve the
    // other write ports in ascending order, skipping the owner itself.
    function automatic int peer_slot(input int num_rd, input int owner, input int peer);
        return num_rd + ((peer < owner) ? peer : peer - 1);
    endfunction

    // Index of a peer word inside a write port's packed peer vector.
    function automatic int peer_lane(input int self_idx, input int other);
        return (other < self_idx) ? other : other - 1;
    endfunction

endpackage

// File: rtl/xor_mp_bank.sv
module xor_mp_bank #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    // Read-first: the registered read sees the array before this edge's write.
    always_comb begin
        rdata_d = mem_q[raddr_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
            if (we_i) begin
                mem_q[waddr_i] <= wdata_i;
            end
        end
    end

    assign rdata_o = rdata_q;

    // R1: the bank leaves reset presenting zero.
    p_clear_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rdata_o == '0));

    // R4: a read of an address committed on the previous edge returns that word.
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we_i, 2) && ($past(raddr_i) == $past(waddr_i, 2)))
        |-> (rdata_o == $past(wdata_i, 2)));

endmodule

// File: rtl/xor_mp_wr_port.sv
module xor_mp_wr_port #(
    parameter  int DATA_W   = 16,
    parameter  int ADDR_W   = 5,
    parameter  int NUM_PEER = 1,
    localparam int PEER_N   = (NUM_PEER > 0) ? NUM_PEER : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        data_i,
    input  logic [PEER_N*DATA_W-1:0] peer_word_i,
    output logic                     we_o,
    output logic [ADDR_W-1:0]        waddr_o,
    output logic [DATA_W-1:0]        wdata_o
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t st_d;
    stage_t st_q;
    logic [DATA_W-1:0] enc;

    // Stage 1: capture the request while the peer banks fetch their words.
    always_comb begin
        st_d      = st_q;
        st_d.vld  = en_i;
        st_d.addr = addr_i;
        st_d.data = data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Stage 2: fold the peers' words into the data so that the XOR over all
    // groups at this address equals the new word.
    always_comb begin
        enc = st_q.data;
        for (int k = 0; k < NUM_PEER; k++) begin
            enc = enc ^ peer_word_i[k*DATA_W +: DATA_W];
        end
    end

    assign we_o    = st_q.vld;
    assign waddr_o = st_q.addr;
    assign wdata_o = enc;

    // R3: a request commits on the following edge, and only then.
    p_commit_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> we_o);

    // R7: no request, no commit.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !we_o);

    // R3: the commit lands at the address that was requested.
    p_addr_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (waddr_o == $past(addr_i)));

endmodule

// File: rtl/xor_mp_rd_port.sv
module xor_mp_rd_port #(
    parameter int DATA_W = 16,
    parameter int NUM_WR = 2
) (
    input  logic [NUM_WR*DATA_W-1:0] share_i,
    output logic [DATA_W-1:0]        data_o
);

    logic [DATA_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int g = 0; g < NUM_WR; g++) begin
            acc = acc ^ share_i[g*DATA_W +: DATA_W];
        end
    end

    assign data_o = acc;

endmodule

// File: rtl/xor_mp_mem.sv
module xor_mp_mem #(
    parameter  int NUM_RD = 3,
    parameter  int NUM_WR = 2,
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_WR-1:0]        wr_en,
    input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
    input  logic [NUM_WR*DATA_W-1:0] wr_data,
    input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
    output logic [NUM_RD*DATA_W-1:0] rd_data
);

    localparam int NUM_PEER = NUM_WR - 1;
    localparam int PEER_N   = (NUM_PEER > 0) ? NUM_PEER : 1;
    localparam int GRP_BK   = NUM_RD + NUM_PEER;

    logic [ADDR_W-1:0] bk_raddr [NUM_WR][GRP_BK];
    logic [DATA_W-1:0] bk_rdata [NUM_WR][GRP_BK];
    logic              grp_we    [NUM_WR];
    logic [ADDR_W-1:0] grp_waddr [NUM_WR];
    logic [DATA_W-1:0] grp_wdata [NUM_WR];

    genvar w, j, r;

    // Bank groups: one per write port, every bank in a group written alike.
    for (w = 0; w < NUM_WR; w++) begin : g_grp
        for (j = 0; j < GRP_BK; j++) begin : g_bank
            if (j < NUM_RD) begin : g_rd_slot
                assign bk_raddr[w][j] = rd_addr[j*ADDR_W +: ADDR_W];
            end else begin : g_wr_slot
                localparam int REQ = (j - NUM_RD < w) ? (j - NUM_RD) : (j - NUM_RD + 1);
                assign bk_raddr[w][j] = wr_addr[REQ*ADDR_W +: ADDR_W];
            end

            xor_mp_bank #(
                .DATA_W (DATA_W),
                .DEPTH  (DEPTH),
                .ADDR_W (ADDR_W)
            ) bank_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .we_i    (grp_we[w]),
                .waddr_i (grp_waddr[w]),
                .wdata_i (grp_wdata[w]),
                .raddr_i (bk_raddr[w][j]),
                .rdata_o (bk_rdata[w][j])
            );
        end
    end

    // Write ports: gather the words the other groups hold for this port.
    for (w = 0; w < NUM_WR; w++) begin : g_wr
        logic [PEER_N*DATA_W-1:0] peer_vec;

        always_comb begin
            peer_vec = '0;
            for (int v = 0; v < NUM_WR; v++) begin
                if (v != w) begin
                    peer_vec[xor_mp_pkg::peer_lane(w, v)*DATA_W +: DATA_W] =
                        bk_rdata[v][xor_mp_pkg::peer_slot(NUM_RD, v, w)];
                end
            end
        end

        xor_mp_wr_port #(
            .DATA_W   (DATA_W),
            .ADDR_W   (ADDR_W),
            .NUM_PEER (NUM_PEER)
        ) wr_port_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .en_i        (wr_en[w]),
            .addr_i      (wr_addr[w*ADDR_W +: ADDR_W]),
            .data_i      (wr_data[w*DATA_W +: DATA_W]),
            .peer_word_i (peer_vec),
            .we_o        (grp_we[w]),
            .waddr_o     (grp_waddr[w]),
            .wdata_o     (grp_wdata[w])
        );
    end

    // Read ports: decode by XOR across one bank of every group.
    for (r = 0; r < NUM_RD; r++) begin : g_rd
        logic [NUM_WR*DATA_W-1:0] share_vec;

        always_comb begin
            share_vec = '0;
            for (int g = 0; g < NUM_WR; g++) begin
                share_vec[g*DATA_W +: DATA_W] = bk_rdata[g][r];
            end
        end

        xor_mp_rd_port #(
            .DATA_W (DATA_W),
            .NUM_WR (NUM_WR)
        ) rd_port_i (
            .share_i (share_vec),
            .data_o  (rd_data[r*DATA_W +: DATA_W])
        );

        if (r > 0) begin : g_same_addr_chk
            // R8: read ports that sampled one address return one word.
            p_ports_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rd_addr[r*ADDR_W +: ADDR_W]) == $past(rd_addr[0 +: ADDR_W]))
                |-> (rd_data[r*DATA_W +: DATA_W] == rd_data[0 +: DATA_W]));
        end
    end

endmodule

// File: tb/xor_mp_mem_tb_top.sv
module xor_mp_mem_tb_top;

    localparam int NR     = 3;
    localparam int NW     = 2;
    localparam int DW     = 16;
    localparam int DEPTH  = 32;
    localparam int AW     = $clog2(DEPTH);
    localparam int CLK_NS = 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NW-1:0]      wr_en;
    logic [NW*AW-1:0]   wr_addr;
    logic [NW*DW-1:0]   wr_data;
    logic [NR*AW-1:0]   rd_addr;
    logic [NR*DW-1:0]   rd_data;

    always #(CLK_NS/2) clk = ~clk;

    xor_mp_mem #(
        .NUM_RD (NR),
        .NUM_WR (NW),
        .DATA_W (DW),
        .DEPTH  (DEPTH)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Behavioural model: a write is applied one edge after it is requested,
    // and reads on an edge see the contents before that edge's commits.
    logic [DW-1:0] m_mem [DEPTH];
    logic          m_pend_en   [NW];
    int            m_pend_addr [NW];
    logic [DW-1:0] m_pend_data [NW];
    logic [DW-1:0] m_exp [NR];
    bit            m_vld;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;
            for (int k = 0; k < NW; k++) m_pend_en[k] = 1'b0;
            m_vld = 1'b0;
        end else begin
            for (int k = 0; k < NR; k++) m_exp[k] = m_mem[int'(rd_addr[k*AW +: AW])];
            for (int k = 0; k < NW; k++)
                if (m_pend_en[k]) m_mem[m_pend_addr[k]] = m_pend_data[k];
            for (int k = 0; k < NW; k++) begin
                m_pend_en[k]   = wr_en[k];
                m_pend_addr[k] = int'(wr_addr[k*AW +: AW]);
                m_pend_data[k] = wr_data[k*DW +: DW];
            end
            m_vld = 1'b1;
        end
    end

    int    n_run  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    prev_en   [NW];
    int    prev_addr [NW];

    task automatic tick();
        @(negedge clk);
        if (m_vld) begin
            for (int k = 0; k < NR; k++) begin
                n_run++;
                if (rd_data[k*DW +: DW] !== m_exp[k]) begin
                    n_fail++;
                    $display("FAIL %s read port %0d: got %h expected %h",
                             cur_req, k, rd_data[k*DW +: DW], m_exp[k]);
                end
            end
        end
    endtask

    task automatic set_wr(input int w, input bit en, input int a, input logic [DW-1:0] d);
        wr_en[w]            = en;
        wr_addr[w*AW +: AW] = AW'(a);
        wr_data[w*DW +: DW] = d;
    endtask

    task automatic set_rd(input int r, input int a);
        rd_addr[r*AW +: AW] = AW'(a);
    endtask

    task automatic all_rd(input int a);
        for (int k = 0; k < NR; k++) set_rd(k, a);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL R5 watchdog: run not complete, got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        wr_en   = '0;
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: sweep all addresses on every port right after reset.
        cur_req = "R1";
        for (int a = 0; a < DEPTH; a++) begin
            for (int k = 0; k < NR; k++) set_rd(k, (a + k) % DEPTH);
            tick();
        end

        // R3: read the target on the request edge, the commit edge, then after.
        cur_req = "R3";
        all_rd(7);
        set_wr(0, 1'b1, 7, 16'hA5C3);
        tick();
        set_wr(0, 1'b0, 0, '0);
        tick();
        tick();
        tick();

        // R2: each write port writes, every read port reads it back;
        // then port 1 overwrites a word that port 0 wrote.
        cur_req = "R2";
        for (int w = 0; w < NW; w++) begin
            set_wr(w, 1'b1, 10 + w, DW'(16'h1200 + w * 16'h0111));
            tick();
            set_wr(w, 1'b0, 0, '0);
            tick();
            all_rd(10 + w);
            tick();
            tick();
        end
        set_wr(1, 1'b1, 7, 16'h3C5A);
        tick();
        set_wr(1, 1'b0, 0, '0);
        tick();
        all_rd(7);
        tick();
        tick();
        set_wr(0, 1'b1, 11, 16'h0F0F);
        tick();
        set_wr(0, 1'b0, 0, '0);
        tick();
        all_rd(11);
        tick();
        tick();

        // R6: both write ports in one cycle, distinct addresses.
        cur_req = "R6";
        set_wr(0, 1'b1, 20, 16'hBEEF);
        set_wr(1, 1'b1, 21, 16'hCAFE);
        tick();
        set_wr(0, 1'b0, 0, '0);
        set_wr(1, 1'b0, 0, '0);
        tick();
        set_rd(0, 20); set_rd(1, 21); set_rd(2, 20);
        tick();
        tick();

        // R7: disabled write ports carry live-looking address and data.
        cur_req = "R7";
        set_wr(0, 1'b0, 20, 16'hFFFF);
        set_wr(1, 1'b0, 21, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            set_rd(0, 20); set_rd(1, 21); set_rd(2, (i % 2 == 0) ? 20 : 21);
            tick();
        end

        // R4: a new address every cycle, no writes, data one cycle later.
        cur_req = "R4";
        set_wr(0, 1'b0, 0, '0);
        set_wr(1, 1'b0, 0, '0);
        for (int i = 0; i < 2 * DEPTH; i++) begin
            for (int k = 0; k < NR; k++) set_rd(k, (i * 3 + k * 5) % DEPTH);
            tick();
        end

        // R5 / R8: random streaming reads alongside random non-conflicting writes.
        cur_req = "R5";
        for (int k = 0; k < NW; k++) begin
            prev_en[k]   = 1'b0;
            prev_addr[k] = 0;
        end
        for (int i = 0; i < 3000; i++) begin
            for (int w = 0; w < NW; w++) begin
                bit en = bit'($urandom % 2);
                int a  = int'($urandom % DEPTH);
                for (int u = 0; u < w; u++)
                    if (wr_en[u] && int'(wr_addr[u*AW +: AW]) == a) en = 1'b0;
                for (int u = 0; u < NW; u++)
                    if (u != w && prev_en[u] && prev_addr[u] == a) en = 1'b0;
                set_wr(w, en, a, DW'($urandom));
            end
            for (int k = 0; k < NR; k++)
                set_rd(k, (i % 4 == 0) ? int'(rd_addr[0 +: AW]) : int'($urandom % DEPTH));
            for (int w = 0; w < NW; w++) begin
                prev_en[w]   = wr_en[w];
                prev_addr[w] = int'(wr_addr[w*AW +: AW]);
            end
            tick();
        end

        // R8: all ports on one address after the random traffic.
        cur_req = "R8";
        set_wr(0, 1'b0, 0, '0);
        set_wr(1, 1'b0, 0, '0);
        tick();
        for (int a = 0; a < DEPTH; a += 3) begin
            all_rd(a);
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule